// File: doc/BRIEF.md
# Keyed Configuration Port

This block is the device end of a two-address configuration window on a byte-wide I/O bus. One address acts as an index port and the next address up acts as a data port. Out of reset the window is closed. A host opens it by writing a fixed four-byte key to the index port. While the window is open, the host writes a register number to the index port and then moves bytes to or from that register through the data port. Writing the exit value to the global control register closes the window again.

The register space behind the window has several parts:
- a logical-device selector;
- a read-only 16-bit identifier, split across two indices;
- a read-only revision nibble;
- a small register file with one bank per logical device.

The logical-device selector chooses which bank the register-file window reaches. Addresses other than the two ports are ignored.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the window is closed. Data-port reads return 0xFF. Once the window is opened, the index register reads 0x00 and the logical-device register (index 0x07) reads 0x00.
- R2: Writing 0x87, 0x01, 0x55, 0x55 in that order to the index port (address 0x2E) opens the window.
- R3: A byte that breaks the key sequence restarts matching. If that byte is 0x87, it counts as the first key byte. A broken sequence leaves the window closed.
- R4: While the window is closed:
  - index-port and data-port reads return 0xFF;
  - data-port writes are dropped;
  - index-port writes feed only the key matcher, so the index and logical-device registers keep their values.
- R5: While the window is open, an index-port write stores the register number, and an index-port read returns it.
- R6: Index 0x07 is the logical-device register. The host can write it and read it back through the data port (address 0x2F).
- R7: Index 0x20 reads the high byte of the identifier (0xA5 by default) and index 0x21 reads the low byte (0xC3 by default). Writes to either index are dropped.
- R8: Index 0x22 reads the revision in bits 3:0 (3 by default), with bits 7:4 reading 0.
- R9: Indices 0x30 to 0x37 reach the register-file bank chosen by the logical-device register. Each bank holds its own values. With a logical-device number of 4 or more, these indices read 0x00 and writes to them are dropped. Unmapped indices read 0x00.
- R10: A data-port write of 0x02 while the index is 0x02 closes the window. Any other value written at index 0x02 leaves the window open.
- R11: Reads and writes at any other bus address have no effect, and such reads return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 16 | I/O address of the current access |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data; 0x00 when no port is read |

## Verification
The key matcher is driven with the clean key and with three broken orderings:
- a stray byte in the last slot;
- a repeated 0x87, which must restart at the second slot rather than at zero;
- a sequence that is correct again only after a restart.

Each broken ordering must leave the index port reading 0xFF, and each recovery must open the window. These cases separate a matcher that resets to zero from one that recognises a fresh first byte.

Register traffic covers several patterns:
- alternating the logical-device number, which shows that banks are independent;
- an out-of-range device number, which shows that bank writes are gated off;
- writes to the identifier indices, which show they are read-only;
- non-exit values at the control index, which separate the exit value from any write to that index.

// File: rtl/kcp_pkg.sv
`timescale 1ns/1ps
package kcp_pkg;
   localparam logic [7:0] KCP_IDX_CTRL  = 8'h02;
   localparam logic [7:0] KCP_CTRL_EXIT = 8'h02;
   localparam logic [7:0] KCP_IDX_LDN   = 8'h07;
   localparam logic [7:0] KCP_IDX_IDHI  = 8'h20;
   localparam logic [7:0] KCP_IDX_IDLO  = 8'h21;
   localparam logic [7:0] KCP_IDX_REV   = 8'h22;
   localparam logic [7:0] KCP_CLOSED_RD = 8'hFF;
endpackage

// File: rtl/kcp_key_match.sv
`timescale 1ns/1ps
module kcp_key_match #(
   parameter int                      KEY_LEN = 4,
   parameter logic [8*KEY_LEN-1:0]    KEY     = 32'h8701_5555
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       key_wr,
   input  logic [7:0] key_byte,
   input  logic       relock,
   output logic       unlocked
);
   localparam int              CW   = $clog2(KEY_LEN + 1);
   localparam logic [CW-1:0]   LAST = CW'(KEY_LEN - 1);

   generate
      if (KEY_LEN < 2) begin : g_bad_len
         $error("kcp_key_match: KEY_LEN must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic [7:0]    exp_byte;
   logic [7:0]    first_byte;

   function automatic logic [7:0] key_at(input logic [CW-1:0] k);
      return KEY[8*(KEY_LEN-1-int'(k)) +: 8];
   endfunction

   assign exp_byte   = key_at(cnt);
   assign first_byte = key_at('0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         unlocked <= 1'b0;
      end else if (relock) begin
         cnt      <= '0;
         unlocked <= 1'b0;
      end else if (key_wr && !unlocked) begin
         if (key_byte == exp_byte) begin
            if (cnt == LAST) begin
               cnt      <= '0;
               unlocked <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end else begin
            cnt <= (key_byte == first_byte) ? CW'(1) : '0;
         end
      end
   end

   AST_OPEN_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> ($past(key_wr) && $past(cnt) == LAST)) else $error("open w/o full key"); // R2
   AST_MISS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (key_wr && !unlocked && !relock && key_byte != exp_byte) |=> (cnt <= CW'(1) && !unlocked)) else $error("miss"); // R3
endmodule

// File: rtl/kcp_ctrl_regs.sv
`timescale 1ns/1ps
module kcp_ctrl_regs (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       idx_we,
   input  logic       ldn_we,
   input  logic [7:0] wdata,
   output logic [7:0] index_q,
   output logic [7:0] ldn_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         index_q <= '0;
         ldn_q   <= '0;
      end else begin
         if (idx_we) index_q <= wdata;
         if (ldn_we) ldn_q   <= wdata;
      end
   end

   AST_LDN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ldn_we |=> $stable(ldn_q)) else $error("ldn moved"); // R6
   AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !idx_we |=> $stable(index_q)) else $error("index moved"); // R5
endmodule

// File: rtl/kcp_bank_rf.sv
`timescale 1ns/1ps
module kcp_bank_rf #(
   parameter int NUM_BANKS = 4,
   parameter int BANK_REGS = 8,
   parameter int BANK_BASE = 8'h30
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] ldn,
   input  logic [7:0] index,
   input  logic [7:0] wdata,
   output logic       hit,
   output logic [7:0] rdata
);
   localparam int          BW      = $clog2(NUM_BANKS);
   localparam int          OW      = $clog2(BANK_REGS);
   localparam int          SW      = BW + OW;
   localparam int          ENTRIES = 1 << SW;
   localparam logic [8:0]  LO      = 9'(BANK_BASE);
   localparam logic [8:0]  HI      = 9'(BANK_BASE + BANK_REGS);
   localparam logic [8:0]  NB      = 9'(NUM_BANKS);

   generate
      if (NUM_BANKS < 2 || (1 << BW) != NUM_BANKS) begin : g_bad_banks
         $error("kcp_bank_rf: NUM_BANKS must be a power of two >= 2");
      end
      if (BANK_REGS < 2 || (1 << OW) != BANK_REGS) begin : g_bad_regs
         $error("kcp_bank_rf: BANK_REGS must be a power of two >= 2");
      end
      if (BANK_BASE + BANK_REGS > 256) begin : g_bad_base
         $error("kcp_bank_rf: window exceeds index space");
      end
   endgenerate

   logic          in_win;
   logic          bank_ok;
   logic [7:0]    off8;
   logic [SW-1:0] sel;
   logic [7:0]    mem [ENTRIES];

   assign in_win  = ({1'b0, index} >= LO) && ({1'b0, index} < HI);
   assign bank_ok = {1'b0, ldn} < NB;
   assign off8    = index - LO[7:0];
   assign sel     = {ldn[BW-1:0], off8[OW-1:0]};
   assign hit     = in_win;

   genvar e;
   generate
      for (e = 0; e < ENTRIES; e++) begin : g_entry
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mem[e] <= '0;
            else if (wr_en && in_win && bank_ok && sel == SW'(e))
               mem[e] <= wdata;
         end
      end
   endgenerate

   assign rdata = (in_win && bank_ok) ? mem[sel] : 8'h00;

   AST_OOR_BANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_win && !bank_ok) |-> rdata == 8'h00) else $error("oor bank read"); // R9
endmodule

// File: rtl/keyed_cfg_port.sv
`timescale 1ns/1ps
module keyed_cfg_port
   import kcp_pkg::*;
#(
   parameter int                   ADDR_W     = 16,
   parameter logic [ADDR_W-1:0]    INDEX_PORT = 16'h002E,
   parameter int                   KEY_LEN    = 4,
   parameter logic [8*KEY_LEN-1:0] KEY        = 32'h8701_5555,
   parameter logic [15:0]          CHIP_ID    = 16'hA5C3,
   parameter logic [3:0]           CHIP_REV   = 4'h3,
   parameter int                   NUM_BANKS  = 4,
   parameter int                   BANK_REGS  = 8,
   parameter int                   BANK_BASE  = 8'h30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata
);
   localparam logic [ADDR_W-1:0] DATA_PORT = INDEX_PORT + 1'b1;

   logic       hit_idx, hit_dat;
   logic       unlocked;
   logic       key_wr, idx_we, dat_we, ldn_we, relock;
   logic [7:0] index_q, ldn_q;
   logic       rf_hit;
   logic [7:0] rf_rdata;

   assign hit_idx = (bus_addr == INDEX_PORT);
   assign hit_dat = (bus_addr == DATA_PORT);
   assign key_wr  = bus_wr && hit_idx && !unlocked;
   assign idx_we  = bus_wr && hit_idx && unlocked;
   assign dat_we  = bus_wr && hit_dat && unlocked;
   assign ldn_we  = dat_we && (index_q == KCP_IDX_LDN);
   assign relock  = dat_we && (index_q == KCP_IDX_CTRL) && (bus_wdata == KCP_CTRL_EXIT);

   kcp_key_match #(.KEY_LEN(KEY_LEN), .KEY(KEY)) u_key (
      .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_byte(bus_wdata),
      .relock(relock), .unlocked(unlocked));

   kcp_ctrl_regs u_ctrl (
      .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .ldn_we(ldn_we),
      .wdata(bus_wdata), .index_q(index_q), .ldn_q(ldn_q));

   kcp_bank_rf #(.NUM_BANKS(NUM_BANKS), .BANK_REGS(BANK_REGS), .BANK_BASE(BANK_BASE)) u_rf (
      .clk(clk), .rst_n(rst_n), .wr_en(dat_we), .ldn(ldn_q), .index(index_q),
      .wdata(bus_wdata), .hit(rf_hit), .rdata(rf_rdata));

   always_comb begin
      bus_rdata = 8'h00;
      if (bus_rd && hit_idx) begin
         bus_rdata = unlocked ? index_q : KCP_CLOSED_RD;
      end else if (bus_rd && hit_dat) begin
         if (!unlocked) begin
            bus_rdata = KCP_CLOSED_RD;
         end else begin
            case (index_q)
               KCP_IDX_LDN:  bus_rdata = ldn_q;
               KCP_IDX_IDHI: bus_rdata = CHIP_ID[15:8];
               KCP_IDX_IDLO: bus_rdata = CHIP_ID[7:0];
               KCP_IDX_REV:  bus_rdata = {4'h0, CHIP_REV};
               default:      bus_rdata = rf_hit ? rf_rdata : 8'h00;
            endcase
         end
      end
   end

   AST_CLOSED_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && (hit_dat || hit_idx) && !unlocked) |-> bus_rdata == 8'hFF) else $error("closed read"); // R4
   AST_CLOSED_NO_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !unlocked) |=> ($stable(ldn_q) && $stable(index_q))) else $error("closed write"); // R4
   AST_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
      relock |=> !unlocked) else $error("relock"); // R10
   AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !hit_idx && !hit_dat) |-> bus_rdata == 8'h00) else $error("foreign read"); // R11
endmodule

// File: tb/tb_keyed_cfg_port.sv
`timescale 1ns/1ps
module tb_keyed_cfg_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = 16'h0000;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_wdata = 8'h00;
   logic [7:0]  bus_rdata;
   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   keyed_cfg_port dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

   // vector: [19:18] 0=write 1=read, [17:16] 0=index 1=data 2=foreign, [15:8] data/expected, [7:0] req
   localparam int N = 77;
   localparam logic [19:0] VEC [N] = '{
      {2'd1,2'd1,8'hFF,8'd1},  {2'd1,2'd0,8'hFF,8'd4},  {2'd0,2'd1,8'h5A,8'd4},           // R1 R4
      {2'd0,2'd0,8'h87,8'd2},  {2'd0,2'd0,8'h01,8'd2},  {2'd0,2'd0,8'h55,8'd2},  {2'd0,2'd0,8'h55,8'd2}, // R2
      {2'd1,2'd0,8'h00,8'd1},  {2'd0,2'd0,8'h07,8'd5},  {2'd1,2'd0,8'h07,8'd5},  {2'd1,2'd1,8'h00,8'd1}, // R5
      {2'd0,2'd1,8'h01,8'd6},  {2'd1,2'd1,8'h01,8'd6},                                     // R6
      {2'd0,2'd0,8'h20,8'd7},  {2'd1,2'd1,8'hA5,8'd7},  {2'd0,2'd0,8'h21,8'd7},  {2'd1,2'd1,8'hC3,8'd7},
      {2'd0,2'd1,8'h00,8'd7},  {2'd1,2'd1,8'hC3,8'd7},                                     // R7
      {2'd0,2'd0,8'h22,8'd8},  {2'd1,2'd1,8'h03,8'd8},                                     // R8
      {2'd0,2'd0,8'h30,8'd9},  {2'd0,2'd1,8'h3C,8'd9},  {2'd1,2'd1,8'h3C,8'd9},
      {2'd0,2'd0,8'h07,8'd9},  {2'd0,2'd1,8'h00,8'd9},  {2'd0,2'd0,8'h30,8'd9},  {2'd1,2'd1,8'h00,8'd9},
      {2'd0,2'd0,8'h31,8'd9},  {2'd0,2'd1,8'h66,8'd9},  {2'd0,2'd0,8'h07,8'd9},  {2'd0,2'd1,8'h05,8'd9},
      {2'd0,2'd0,8'h31,8'd9},  {2'd0,2'd1,8'h99,8'd9},  {2'd1,2'd1,8'h00,8'd9},  {2'd0,2'd0,8'h07,8'd9},
      {2'd0,2'd1,8'h00,8'd9},  {2'd0,2'd0,8'h31,8'd9},  {2'd1,2'd1,8'h66,8'd9},              // R9
      {2'd0,2'd0,8'h50,8'd9},  {2'd1,2'd1,8'h00,8'd9},
      {2'd0,2'd2,8'h07,8'd11}, {2'd1,2'd2,8'h00,8'd11}, {2'd1,2'd0,8'h50,8'd11},             // R11
      {2'd0,2'd0,8'h07,8'd9},  {2'd0,2'd1,8'h01,8'd9},  {2'd0,2'd0,8'h30,8'd9},  {2'd1,2'd1,8'h3C,8'd9},
      {2'd0,2'd0,8'h02,8'd10}, {2'd0,2'd1,8'h01,8'd10}, {2'd1,2'd0,8'h02,8'd10},
      {2'd0,2'd1,8'h02,8'd10}, {2'd1,2'd1,8'hFF,8'd10}, {2'd1,2'd0,8'hFF,8'd10},             // R10
      {2'd0,2'd0,8'h07,8'd4},  {2'd0,2'd1,8'h03,8'd4},                                     // R4
      {2'd0,2'd0,8'h87,8'd3},  {2'd0,2'd0,8'h87,8'd3},  {2'd0,2'd0,8'h01,8'd3},  {2'd0,2'd0,8'h55,8'd3},
      {2'd0,2'd0,8'h55,8'd3},                                                              // R3
      {2'd1,2'd0,8'h02,8'd4},  {2'd0,2'd0,8'h07,8'd4},  {2'd1,2'd1,8'h01,8'd4},
      {2'd0,2'd0,8'h02,8'd10}, {2'd0,2'd1,8'h02,8'd10},
      {2'd0,2'd0,8'h87,8'd3},  {2'd0,2'd0,8'h01,8'd3},  {2'd0,2'd0,8'h55,8'd3},  {2'd0,2'd0,8'h13,8'd3},
      {2'd0,2'd0,8'h55,8'd3},  {2'd1,2'd0,8'hFF,8'd3},
      {2'd0,2'd0,8'h87,8'd3},  {2'd0,2'd0,8'h01,8'd3},  {2'd0,2'd0,8'h55,8'd3},  {2'd0,2'd0,8'h55,8'd3},
      {2'd1,2'd0,8'h02,8'd3}
   };

   function automatic logic [15:0] port_addr(input logic [1:0] p);
      return (p == 2'd0) ? 16'h002E : (p == 2'd1) ? 16'h002F : 16'h0040;
   endfunction

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string req);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #2;
      n_chk++;
      if (bus_rdata !== exp) begin
         n_fail++;
         $display("FAIL %s addr=%h actual=%h expected=%h", req, a, bus_rdata, exp);
      end
      bus_rd = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(20 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < N; i++) begin
         if (VEC[i][19:18] == 2'd0)
            wr(port_addr(VEC[i][17:16]), VEC[i][15:8]);
         else
            rd(port_addr(VEC[i][17:16]), VEC[i][15:8], $sformatf("R%0d", VEC[i][7:0]));
      end
      // directed: key broken in its last slot by 0x87, then completed (R3)
      wr(16'h002E, 8'h02); wr(16'h002F, 8'h02);
      wr(16'h002E, 8'h87); wr(16'h002E, 8'h01); wr(16'h002E, 8'h55); wr(16'h002E, 8'h87);
      rd(16'h002E, 8'hFF, "R3");
      wr(16'h002E, 8'h01); wr(16'h002E, 8'h55); wr(16'h002E, 8'h55);
      rd(16'h002E, 8'h02, "R3");
      // directed: reset while open returns to closed with cleared registers (R1)
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      rd(16'h002F, 8'hFF, "R1");
      rd(16'h002E, 8'hFF, "R1");
      wr(16'h002E, 8'h87); wr(16'h002E, 8'h01); wr(16'h002E, 8'h55); wr(16'h002E, 8'h55);
      rd(16'h002E, 8'h00, "R1");
      wr(16'h002E, 8'h07);
      rd(16'h002F, 8'h00, "R1");
      wr(16'h002E, 8'h30);
      rd(16'h002F, 8'h00, "R1");
      finish_run();
   end
endmodule